// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. A 14-bit virtual address splits into an 8-bit virtual page number and a 6-bit byte offset, so pages are 64 bytes. The walker receives the page number and the access kind of a missed lookup, and uses a directory base address to read one directory entry. That entry holds the frame of a page-table page. The walker then reads the leaf entry from that page and either writes the translation into the TLB or reports a fault. The fault is one of three kinds: segmentation, protection or not present.

Reads go out one at a time on a request/grant port, and the data returns later on a separate valid strobe. The walker handles one miss at a time. It accepts no new miss until the current walk has finished and it has returned to idle. Its single-cycle fill pulse also tells the requester to retry the access.

Top module: `ptw_walker`

## Requirements
- R1: The upper 4 bits of the page number select the directory entry and the lower 4 bits select the table entry. The directory entry is read at `dir_base_i + 4*dir_index`.
- R2: Every entry is a 32-bit word. Bit 0 is valid and bit 1 is present. Bits 4:2 are the permissions: bit 2 read, bit 3 write, bit 4 execute. Bits 17:8 hold the 10-bit frame number. The access kind uses the same 3-bit read/write/execute layout.
- R3: The leaf entry is read at `(directory_frame << 6) + 4*table_index`.
- R4: If the directory entry is invalid, the walker reports a segmentation fault (code 01) and issues no second read.
- R5: If the leaf entry is invalid, the walker reports a segmentation fault (code 01), whatever its other bits hold.
- R6: A valid leaf whose permissions lack any bit requested by the access kind gives a protection fault (code 10). This holds even when the leaf is also not present.
- R7: A valid, permitted leaf whose present bit is clear gives a not-present fault (code 11).
- R8: On success, `fill_valid_o` pulses for one cycle. It carries the page number, the leaf frame number and the leaf permissions, and the pulse is the retry signal.
- R9: `fault_valid_o` lasts exactly one cycle per fault. A fill and a fault are never signalled together, and each walk yields exactly one result.
- R10: `miss_ready_o` is high only while idle. A miss presented during a walk is ignored.
- R11: A read request holds a stable address until it is granted. At most one read is outstanding at a time.
- R12: After reset the walker is idle and ready, with no request, fill or fault asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_base_i | input | 16 | Physical base address of the page directory |
| miss_valid_i | input | 1 | Translation miss presented |
| miss_ready_o | output | 1 | Walker idle and able to take a miss |
| miss_vpn_i | input | 8 | Missed virtual page number |
| miss_acc_i | input | 3 | Requested access kind, one bit each for read/write/execute |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read byte address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (one entry) |
| fill_valid_o | output | 1 | TLB fill and retry pulse |
| fill_vpn_o | output | 8 | Page number being filled |
| fill_pfn_o | output | 10 | Translated frame number |
| fill_prot_o | output | 3 | Permissions of the translation |
| fault_valid_o | output | 1 | Fault pulse |
| fault_code_o | output | 2 | Fault kind: 01 segmentation, 10 protection, 11 not present |

## Verification
A miss accepted on one edge raises the first read request in the next cycle. Each grant moves the walker to its waiting state, and a second request follows one cycle after the directory response. The fill or fault appears in the cycle right after the edge that takes the final read response, and lasts one cycle. The memory model varies grant and response delays between walks, so these results move with those delays and no fixed cycle count can be assumed. The scoreboard therefore matches results in arrival order: it samples every output on the falling edge and pops one expected item per observed pulse. It also compares the number of reads each walk consumed, so a second read after an invalid directory entry, or a pulse held for two cycles, shows up as a mismatch.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_PDE,
    ST_WAIT_PDE,
    ST_RD_PTE,
    ST_WAIT_PTE,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_SEG    = 2'b01,
    FLT_PROT   = 2'b10,
    FLT_ABSENT = 2'b11
  } fault_code_e;

  localparam int unsigned EntValidBit   = 0;
  localparam int unsigned EntPresentBit = 1;
  localparam int unsigned EntProtLsb    = 2;
  localparam int unsigned ProtW         = 3;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned PA_W   = 16,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned DIR_W  = 4,
  parameter int unsigned TBL_W  = 4,
  parameter int unsigned ENT_LG = 2
) (
  input  logic [PA_W-1:0]       dir_base_i,
  input  logic [DIR_W-1:0]      dir_idx_i,
  input  logic [TBL_W-1:0]      tbl_idx_i,
  input  logic [PA_W-OFF_W-1:0] tbl_pfn_i,
  input  logic                  leaf_i,
  output logic [PA_W-1:0]       addr_o
);
  localparam int unsigned PFN_W = PA_W - OFF_W;

  logic [PA_W-1:0] pde_addr, pte_addr;

  assign pde_addr = dir_base_i + PA_W'({dir_idx_i, {ENT_LG{1'b0}}});
  assign pte_addr = {tbl_pfn_i, {OFF_W{1'b0}}} + PA_W'({tbl_idx_i, {ENT_LG{1'b0}}});
  assign addr_o   = leaf_i ? pte_addr : pde_addr;

  // R3: a leaf address always lands inside the page named by the frame
  always_comb begin
    if (leaf_i) begin
      pte_in_page_chk: assert (pte_addr[PA_W-1:OFF_W] == PFN_W'(tbl_pfn_i));
    end
  end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int unsigned ENT_W   = 32,
  parameter int unsigned PFN_LSB = 8,
  parameter int unsigned PFN_W   = 10
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic [ProtW-1:0] acc_i,
  input  logic             leaf_i,
  output fault_code_e      code_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic [ProtW-1:0] prot_o
);
  localparam int unsigned PFN_HI = PFN_LSB + PFN_W;

  logic valid, present;
  logic unused_bits;

  assign valid       = ent_i[EntValidBit];
  assign present     = ent_i[EntPresentBit];
  assign prot_o      = ent_i[EntProtLsb +: ProtW];
  assign pfn_o       = ent_i[PFN_LSB +: PFN_W];
  assign unused_bits = ^{ent_i[ENT_W-1:PFN_HI], ent_i[PFN_LSB-1:EntProtLsb+ProtW]};

  // fixed priority: valid, permission, presence
  always_comb begin
    if (!valid)                       code_o = FLT_SEG;
    else if (!leaf_i)                 code_o = FLT_NONE;
    else if ((acc_i & ~prot_o) != '0) code_o = FLT_PROT;
    else if (!present)                code_o = FLT_ABSENT;
    else                              code_o = FLT_NONE;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W    = 16,
  parameter int unsigned VA_W    = 14,
  parameter int unsigned OFF_W   = 6,
  parameter int unsigned ENT_W   = 32,
  parameter int unsigned PFN_LSB = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PA_W-1:0]       dir_base_i,
  input  logic                  miss_valid_i,
  output logic                  miss_ready_o,
  input  logic [VA_W-OFF_W-1:0] miss_vpn_i,
  input  logic [2:0]            miss_acc_i,
  output logic                  mem_req_o,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic                  mem_gnt_i,
  input  logic                  mem_rvalid_i,
  input  logic [ENT_W-1:0]      mem_rdata_i,
  output logic                  fill_valid_o,
  output logic [VA_W-OFF_W-1:0] fill_vpn_o,
  output logic [PA_W-OFF_W-1:0] fill_pfn_o,
  output logic [2:0]            fill_prot_o,
  output logic                  fault_valid_o,
  output logic [1:0]            fault_code_o
);
  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned ENT_LG = $clog2(ENT_W / 8);
  localparam int unsigned TBL_W  = OFF_W - ENT_LG;
  localparam int unsigned DIR_W  = VPN_W - TBL_W;
  localparam int unsigned PFN_W  = PA_W - OFF_W;

  walk_state_e        state_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [ProtW-1:0]   acc_q, prot_q;
  logic [PFN_W-1:0]   pfn_q;
  fault_code_e        code_q;

  logic               leaf;
  fault_code_e        chk_code;
  logic [PFN_W-1:0]   chk_pfn;
  logic [ProtW-1:0]   chk_prot;

  assign leaf = (state_q == ST_RD_PTE) || (state_q == ST_WAIT_PTE);

  ptw_addr_gen #(
    .PA_W(PA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .ENT_LG(ENT_LG)
  ) u_addr (
    .dir_base_i (dir_base_i),
    .dir_idx_i  (vpn_q[VPN_W-1 -: DIR_W]),
    .tbl_idx_i  (vpn_q[TBL_W-1:0]),
    .tbl_pfn_i  (pfn_q),
    .leaf_i     (leaf),
    .addr_o     (mem_addr_o)
  );

  ptw_entry_check #(
    .ENT_W(ENT_W), .PFN_LSB(PFN_LSB), .PFN_W(PFN_W)
  ) u_check (
    .ent_i  (mem_rdata_i),
    .acc_i  (acc_q),
    .leaf_i (leaf),
    .code_o (chk_code),
    .pfn_o  (chk_pfn),
    .prot_o (chk_prot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      acc_q   <= '0;
      prot_q  <= '0;
      pfn_q   <= '0;
      code_q  <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid_i) begin
          vpn_q   <= miss_vpn_i;
          acc_q   <= miss_acc_i;
          state_q <= ST_RD_PDE;
        end
        ST_RD_PDE: if (mem_gnt_i) state_q <= ST_WAIT_PDE;
        ST_WAIT_PDE: if (mem_rvalid_i) begin
          if (chk_code != FLT_NONE) begin
            code_q  <= chk_code;
            state_q <= ST_FAULT;
          end else begin
            pfn_q   <= chk_pfn;
            state_q <= ST_RD_PTE;
          end
        end
        ST_RD_PTE: if (mem_gnt_i) state_q <= ST_WAIT_PTE;
        ST_WAIT_PTE: if (mem_rvalid_i) begin
          if (chk_code != FLT_NONE) begin
            code_q  <= chk_code;
            state_q <= ST_FAULT;
          end else begin
            pfn_q   <= chk_pfn;
            prot_q  <= chk_prot;
            state_q <= ST_DONE;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o     = (state_q == ST_RD_PDE) || (state_q == ST_RD_PTE);
  assign fill_valid_o  = (state_q == ST_DONE);
  assign fill_vpn_o    = vpn_q;
  assign fill_pfn_o    = pfn_q;
  assign fill_prot_o   = prot_q;
  assign fault_valid_o = (state_q == ST_FAULT);
  assign fault_code_o  = (state_q == ST_FAULT) ? code_q : FLT_NONE;

  // R9
  fill_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_valid_o));

  // R9
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |=> !fault_valid_o);

  // R9
  fault_code_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> fault_code_o != 2'b00);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !miss_ready_o);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  fill_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_valid_o) |-> $past(mem_rvalid_i));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DIR_BASE = 16'h0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [7:0]  miss_vpn = '0;
  logic [2:0]  miss_acc = '0;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        miss_ready, mem_req, fill_valid, fault_valid;
  logic [15:0] mem_addr;
  logic [7:0]  fill_vpn;
  logic [9:0]  fill_pfn;
  logic [2:0]  fill_prot;
  logic [1:0]  fault_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .dir_base_i(DIR_BASE),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
    .miss_vpn_i(miss_vpn), .miss_acc_i(miss_acc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .fill_valid_o(fill_valid), .fill_vpn_o(fill_vpn), .fill_pfn_o(fill_pfn),
    .fill_prot_o(fill_prot), .fault_valid_o(fault_valid), .fault_code_o(fault_code)
  );

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int n_exp  = 0;
  int n_res  = 0;
  int gnt_wait = 0;
  int rsp_wait = 0;
  bit done = 0;

  int unsigned mem [int];

  // expected item: {is_fault, code, pfn, prot, vpn}
  logic [23:0] exp_q[$];
  int          exp_reads_q[$];
  int          exp_start_q[$];
  string       req_q[$];

  function automatic int unsigned rd(input int a);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  // R2 entry layout: valid bit 0, present bit 1, prot 4:2, frame 17:8
  task automatic set_ent(input int a, input bit v, input bit p,
                         input logic [2:0] prot, input logic [9:0] pfn);
    mem[a] = (int'(pfn) << 8) | (int'(prot) << 2) | (int'(p) << 1) | int'(v);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: grant after gnt_wait, data after rsp_wait
  initial begin
    forever begin
      @(negedge clk);
      mem_gnt = 1'b0;
      mem_rvalid = 1'b0;
      if (mem_req && rst_n) begin
        logic [15:0] a;
        a = mem_addr;
        for (int i = 0; i < gnt_wait; i++) begin
          @(negedge clk);
          check(mem_req && mem_addr == a, "R11", "request held", {15'd0, mem_req, mem_addr}, {16'd1, a});
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        check(!mem_req, "R11", "single outstanding", {31'd0, mem_req}, 32'd0);
        for (int i = 0; i < rsp_wait; i++) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = rd(int'(a));
        reads++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (fill_valid || fault_valid)) begin
        logic [23:0] act;
        n_res++;
        check(!(fill_valid && fault_valid), "R9", "fill and fault together",
              {30'd0, fill_valid, fault_valid}, 32'd0);
        act = fault_valid ? {1'b1, fault_code, 21'd0} : {1'b0, 2'b00, fill_pfn, fill_prot, fill_vpn};
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected result", {8'd0, act}, 32'd0);
        end else begin
          logic [23:0] e;
          string r;
          int er, es;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          er = exp_reads_q.pop_front();
          es = exp_start_q.pop_front();
          check(act == e, r, "result", {8'd0, act}, {8'd0, e});
          check(reads - es == er, r, "read count", reads - es, er);
        end
      end
    end
  end

  // expected outcome from the requirements
  task automatic walk(input logic [7:0] vpn, input logic [2:0] acc, input string req);
    int unsigned pde, pte;
    logic [23:0] e;
    int nr;
    pde = rd(int'(DIR_BASE) + int'(vpn[7:4]) * 4);             // R1
    if (pde[0] == 1'b0) begin
      e = {1'b1, 2'b01, 21'd0}; nr = 1;                         // R4
    end else begin
      pte = rd(int'(pde[17:8]) * 64 + int'(vpn[3:0]) * 4);     // R3
      nr = 2;
      if (pte[0] == 1'b0) e = {1'b1, 2'b01, 21'd0};             // R5
      else if ((acc & ~pte[4:2]) != 3'b000) e = {1'b1, 2'b10, 21'd0}; // R6
      else if (pte[1] == 1'b0) e = {1'b1, 2'b11, 21'd0};        // R7
      else e = {1'b0, 2'b00, pte[17:8], pte[4:2], vpn};         // R8
    end
    exp_q.push_back(e);
    req_q.push_back(req);
    exp_reads_q.push_back(nr);
    exp_start_q.push_back(reads);
    n_exp++;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1; miss_vpn = vpn; miss_acc = acc;
    @(negedge clk);
    miss_valid = 1'b0;
    check(!miss_ready, "R10", "busy after accept", {31'd0, miss_ready}, 32'd0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R11 watchdog: actual=timeout expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // directory: idx1 -> frame 0x20, idx2 invalid, idx15 -> frame 0x3FF
    set_ent(int'(DIR_BASE) + 1*4, 1, 1, 3'b000, 10'h020);
    set_ent(int'(DIR_BASE) + 2*4, 0, 1, 3'b111, 10'h030);
    set_ent(int'(DIR_BASE) + 15*4, 1, 0, 3'b000, 10'h3FF);
    set_ent(32'h20*64 + 0*4,  1, 1, 3'b011, 10'h155);
    set_ent(32'h20*64 + 3*4,  0, 1, 3'b111, 10'h0AA);
    set_ent(32'h20*64 + 5*4,  1, 0, 3'b001, 10'h011);
    set_ent(32'h20*64 + 6*4,  1, 0, 3'b111, 10'h012);
    set_ent(32'h20*64 + 15*4, 1, 1, 3'b100, 10'h2AA);
    set_ent(32'h3FF*64 + 15*4, 1, 1, 3'b111, 10'h3FF);

    repeat (3) @(negedge clk);
    // R12: reset state
    check(miss_ready && !mem_req && !fill_valid && !fault_valid, "R12", "reset outputs",
          {28'd0, miss_ready, mem_req, fill_valid, fault_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(miss_ready && !mem_req, "R12", "idle after reset", {30'd0, miss_ready, mem_req}, 32'h2);

    walk(8'h10, 3'b001, "R1 R3 R8 read hit");
    gnt_wait = 2; rsp_wait = 1;
    walk(8'h10, 3'b100, "R6 exec denied");
    walk(8'h13, 3'b001, "R5 invalid leaf");
    gnt_wait = 0; rsp_wait = 3;
    walk(8'h15, 3'b010, "R6 over R7 order");
    walk(8'h15, 3'b001, "R7 not present");
    gnt_wait = 1; rsp_wait = 0;
    walk(8'h16, 3'b100, "R7 absent rwx");
    walk(8'h1F, 3'b100, "R8 exec hit");
    walk(8'h20, 3'b001, "R4 invalid directory");
    walk(8'h11, 3'b000, "R5 empty leaf");
    gnt_wait = 3; rsp_wait = 2;
    walk(8'hFF, 3'b111, "R1 R3 R8 top frame");
    walk(8'h2F, 3'b111, "R4 invalid directory");

    // R10: misses offered mid-walk are ignored
    gnt_wait = 1; rsp_wait = 1;
    fork
      walk(8'h10, 3'b011, "R8 R10 walk under noise");
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        miss_valid = 1'b1; miss_vpn = 8'h20; miss_acc = 3'b001;
        @(negedge clk);
        check(!miss_ready, "R10", "ready while busy", {31'd0, miss_ready}, 32'd0);
        @(negedge clk);
        miss_valid = 1'b0;
      end
    join
    repeat (12) @(negedge clk);
    check(n_res == n_exp, "R10", "result count", n_res, n_exp);
    check(miss_ready && !mem_req, "R10", "idle at end", {30'd0, miss_ready, mem_req}, 32'h2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule